// File: doc/BRIEF.md
# Half-Precision Round-to-Integral Unit

This block takes one binary16 floating-point operand and returns the nearest integral value, still encoded as binary16. The direction of rounding comes either from a mode chosen by the operation or from a dynamic mode word held elsewhere in a status register. A per-operation select picks between the two.

The unit keeps a sticky set of exception flags. An "exact" request may raise the inexact flag when the result differs from the operand. A normal request never newly sets inexact, but it still raises invalid for a signalling NaN. Each strobed operand produces its result, an output valid and the updated flags one clock later.

Mode codes are 0 ties-to-even, 1 toward minus infinity, 2 toward plus infinity, 3 toward zero and 4 ties-away-from-zero. Codes 5 to 7 act as code 0. The flags output carries inexact in bit 0 and invalid in bit 1.

Top module: `fp16_rint`

## Requirements
- R1: While reset is held and after it is released, `out_valid` is 0 and `flags_o` is 2'b00.
- R2: The result and `out_valid`=1 appear on the clock edge after a cycle with `in_valid`=1. `out_valid` is 0 on the edge after a cycle with `in_valid`=0, and the result register then keeps its value.
- R3: Mode code 0 rounds to the nearest integer. A value exactly halfway between two integers goes to the even one, so 2.5 gives 2.0 and 3.5 gives 4.0.
- R4: Mode code 1 rounds toward minus infinity, so -1.5 gives -2.0. Mode code 2 rounds toward plus infinity, so -1.5 gives -1.0.
- R5: Mode code 3 truncates toward zero. Mode code 4 rounds to nearest with halfway cases away from zero, so -2.5 gives -3.0.
- R6: When `use_dyn`=1 the mode comes from `dyn_rmode` and `mode_sel` is ignored. When `use_dyn`=0 the mode comes from `mode_sel`.
- R7: A nonzero operand of magnitude below 1.0, including subnormals, gives either a zero with the operand's sign or ±1.0 with the operand's sign, as the mode dictates.
- R8: Three kinds of operand are returned unchanged and raise no flag: a biased exponent field of 25 or more (magnitude 1024 and up), infinities, and signed zeros.
- R9: With `exact`=1, the inexact flag (bit 0) is set whenever the result differs from a finite operand. If the result equals the operand, the flag is left alone.
- R10: With `exact`=0, inexact is never newly set. An inexact flag that is already set stays set.
- R11: A signalling NaN (exponent all ones, nonzero mantissa, mantissa MSB 0) sets invalid (bit 1) in either variant. It returns the same value with the mantissa MSB set. A quiet NaN is returned unchanged and raises no flag.
- R12: Flag bits are sticky: once set, they stay set through later operations until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand strobe |
| in_op | input | 16 | binary16 operand |
| mode_sel | input | 3 | Rounding mode chosen by the operation |
| use_dyn | input | 1 | 1: use `dyn_rmode`, 0: use `mode_sel` |
| dyn_rmode | input | 3 | Dynamic rounding mode from the status register |
| exact | input | 1 | 1: inexact may be raised, 0: inexact suppressed |
| res_o | output | 16 | Registered integral result |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| flags_o | output | 2 | Sticky flags: bit 0 inexact, bit 1 invalid |

## Verification
The bench builds the unit with its default field widths, a 5-bit exponent and a 10-bit mantissa. At these widths every exponent regime can be reached with hand-picked operands: the sub-one range, each of the ten fractional-bit widths, the 1024 pass-through threshold, and the NaN and infinity codes. Halfway operands with odd and even integer parts separate the two nearest modes. Resets between scenarios let the bench observe, at the flag port, whether inexact was newly set or kept.

// File: rtl/fp16_rint_pkg.sv
// Shared types for the round-to-integral unit.
// Assumes a 3-bit mode code and a two-bit sticky flag set.
package fp16_rint_pkg;
    typedef enum logic [2:0] {
        RM_NEAR_EVEN = 3'd0,
        RM_DOWN      = 3'd1,
        RM_UP        = 3'd2,
        RM_ZERO      = 3'd3,
        RM_NEAR_AWAY = 3'd4
    } rint_mode_e;

    localparam int FLG_W  = 2;
    localparam int FLG_NX = 0;
    localparam int FLG_NV = 1;
endpackage

// File: rtl/rint_mode_pick.sv
// Resolves the effective rounding mode from the forced and dynamic codes.
// Assumes codes 5..7 are reserved and behave as ties-to-even.
module rint_mode_pick
    import fp16_rint_pkg::*;
(
    input  logic [2:0]  sel_i,
    input  logic [2:0]  dyn_i,
    input  logic        use_dyn_i,
    output rint_mode_e  rmode_o
);
    logic [2:0] code;

    // choose the source and map the code onto a known mode
    always_comb begin
        code = use_dyn_i ? dyn_i : sel_i;
        case (code)
            3'd1:    rmode_o = RM_DOWN;
            3'd2:    rmode_o = RM_UP;
            3'd3:    rmode_o = RM_ZERO;
            3'd4:    rmode_o = RM_NEAR_AWAY;
            default: rmode_o = RM_NEAR_EVEN;
        endcase
    end
endmodule

// File: rtl/rint_core.sv
// Combinational rounding of one binary floating-point value to an integer.
// Assumes IEEE field layout; reports invalid and inexact raises, no state.
module rint_core
    import fp16_rint_pkg::*;
#(
    parameter int EXP_W = 5,
    parameter int MAN_W = 10
) (
    input  logic [EXP_W+MAN_W:0]  op_i,
    input  rint_mode_e            rmode_i,
    output logic [EXP_W+MAN_W:0]  res_o,
    output logic                  raise_nv_o,
    output logic                  raise_nx_o
);
    localparam int W       = 1 + EXP_W + MAN_W;
    localparam int MAG_W   = EXP_W + MAN_W;
    localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
    localparam int SH_BASE = BIAS + MAN_W;
    localparam logic [EXP_W-1:0] EMAX   = '1;
    localparam logic [W-1:0]     QBIT   = W'(1) << (MAN_W - 1);
    localparam logic [MAG_W-1:0] ONE_MG = {EXP_W'(BIAS), {MAN_W{1'b0}}};

    logic             sgn;
    logic [EXP_W-1:0] expf;
    logic [MAN_W-1:0] manf;
    logic [MAG_W-1:0] mag, unit, mask, frac, half, trunc;
    logic [EXP_W:0]   sh;
    logic             lsb, rnd_up;

    // classify the operand and form the rounded result
    always_comb begin
        sgn        = op_i[W-1];
        expf       = op_i[W-2:MAN_W];
        manf       = op_i[MAN_W-1:0];
        mag        = op_i[MAG_W-1:0];
        sh         = (EXP_W+1)'(SH_BASE) - {1'b0, expf};
        unit       = MAG_W'(1) << sh;
        mask       = unit - MAG_W'(1);
        frac       = mag & mask;
        half       = unit >> 1;
        trunc      = mag & ~mask;
        lsb        = |(mag & unit);
        rnd_up     = 1'b0;
        res_o      = op_i;
        raise_nv_o = 1'b0;
        raise_nx_o = 1'b0;
        if (expf == EMAX) begin
            if (manf != '0 && !manf[MAN_W-1]) begin
                raise_nv_o = 1'b1;
                res_o      = op_i | QBIT;
            end
        end else if (mag == '0) begin
            res_o = op_i;
        end else if ({1'b0, expf} >= (EXP_W+1)'(SH_BASE)) begin
            res_o = op_i;
        end else if (expf < EXP_W'(BIAS)) begin
            raise_nx_o = 1'b1;
            case (rmode_i)
                RM_NEAR_EVEN: rnd_up = (expf == EXP_W'(BIAS - 1)) && (manf != '0);
                RM_NEAR_AWAY: rnd_up = (expf == EXP_W'(BIAS - 1));
                RM_DOWN:      rnd_up = sgn;
                RM_UP:        rnd_up = !sgn;
                default:      rnd_up = 1'b0;
            endcase
            res_o = {sgn, rnd_up ? ONE_MG : {MAG_W{1'b0}}};
        end else begin
            raise_nx_o = (frac != '0);
            case (rmode_i)
                RM_NEAR_EVEN: rnd_up = (frac > half) || ((frac == half) && lsb);
                RM_NEAR_AWAY: rnd_up = (frac >= half);
                RM_DOWN:      rnd_up = sgn && (frac != '0);
                RM_UP:        rnd_up = !sgn && (frac != '0);
                default:      rnd_up = 1'b0;
            endcase
            res_o = {sgn, trunc + (rnd_up ? unit : {MAG_W{1'b0}})};
        end
    end
endmodule

// File: rtl/fp16_rint.sv
// Round-to-integral unit: mode pick, rounding core, result and sticky flags.
// Assumes one operand per strobe; result and flags land one cycle later.
module fp16_rint
    import fp16_rint_pkg::*;
#(
    parameter int EXP_W = 5,
    parameter int MAN_W = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [EXP_W+MAN_W:0]  in_op,
    input  logic [2:0]            mode_sel,
    input  logic                  use_dyn,
    input  logic [2:0]            dyn_rmode,
    input  logic                  exact,
    output logic [EXP_W+MAN_W:0]  res_o,
    output logic                  out_valid,
    output logic [FLG_W-1:0]      flags_o
);
    localparam int W     = 1 + EXP_W + MAN_W;
    localparam int MAG_W = EXP_W + MAN_W;
    localparam int BIAS  = (1 << (EXP_W - 1)) - 1;

    rint_mode_e       rmode;
    logic [W-1:0]     core_res, res_q;
    logic             core_nv, core_nx, vld_q;
    logic [FLG_W-1:0] flags_q;

    rint_mode_pick u_pick (
        .sel_i     (mode_sel),
        .dyn_i     (dyn_rmode),
        .use_dyn_i (use_dyn),
        .rmode_o   (rmode)
    );

    rint_core #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_core (
        .op_i       (in_op),
        .rmode_i    (rmode),
        .res_o      (core_res),
        .raise_nv_o (core_nv),
        .raise_nx_o (core_nx)
    );

    // capture the result and valid on each strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= in_valid;
            if (in_valid) res_q <= core_res;
        end
    end

    // accumulate sticky flags; inexact only from the exact variant
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else if (in_valid) begin
            flags_q[FLG_NV] <= flags_q[FLG_NV] | core_nv;
            flags_q[FLG_NX] <= flags_q[FLG_NX] | (exact & core_nx);
        end
    end

    assign res_o     = res_q;
    assign out_valid = vld_q;
    assign flags_o   = flags_q;

    logic [EXP_W-1:0] chk_exp;
    logic [EXP_W:0]   chk_sh;
    logic [MAG_W-1:0] chk_mask;

    // fractional-bit mask of the registered result, for checking only
    always_comb begin
        chk_exp  = res_q[W-2:MAN_W];
        chk_sh   = (EXP_W+1)'(BIAS + MAN_W) - {1'b0, chk_exp};
        chk_mask = (MAG_W'(1) << chk_sh) - MAG_W'(1);
    end

    // R10
    nx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !exact && !flags_q[FLG_NX]) |=> !flags_q[FLG_NX]);

    // R12
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

    // R7
    tiny_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (chk_exp < EXP_W'(BIAS))) |-> (res_q[MAG_W-1:0] == '0));

    // R3
    integral_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (chk_exp >= EXP_W'(BIAS)) && ({1'b0, chk_exp} < (EXP_W+1)'(BIAS + MAN_W)))
        |-> ((res_q[MAG_W-1:0] & chk_mask) == '0));

    // R11
    snan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_op[W-2:MAN_W] == '1) && (in_op[MAN_W-1:0] != '0) && !in_op[MAN_W-1])
        |=> (flags_q[FLG_NV] && res_q[MAN_W-1] && (res_q[MAN_W-2:0] == $past(in_op[MAN_W-2:0]))));

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(res_q)));
endmodule

// File: tb/fp16_rint_tb.sv
`timescale 1ns/1ps
module fp16_rint_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_op = '0;
    logic [2:0]  mode_sel = '0;
    logic        use_dyn = 1'b0;
    logic [2:0]  dyn_rmode = '0;
    logic        exact = 1'b0;
    logic [15:0] res_o;
    logic        out_valid;
    logic [1:0]  flags_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fp16_rint u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .mode_sel(mode_sel), .use_dyn(use_dyn), .dyn_rmode(dyn_rmode),
        .exact(exact), .res_o(res_o), .out_valid(out_valid), .flags_o(flags_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n    = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // drive one operand, sample at the negedge after its capture edge
    task automatic run(input string tag, input logic [15:0] op, input logic [2:0] md,
                       input logic ud, input logic [2:0] dm, input logic ex,
                       input logic [15:0] exp_res);
        @(negedge clk);
        in_valid  = 1'b1;
        in_op     = op;
        mode_sel  = md;
        use_dyn   = ud;
        dyn_rmode = dm;
        exact     = ex;
        @(negedge clk);
        in_valid = 1'b0;
        chk(tag, {16'h0, res_o}, {16'h0, exp_res});
        chk({tag, " valid"}, {31'h0, out_valid}, 32'd1);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 reset valid", {31'h0, out_valid}, 32'd0);
        chk("R1 reset flags", {30'h0, flags_o}, 32'd0);
        do_reset();
        chk("R1 post-reset flags", {30'h0, flags_o}, 32'd0);
    endtask

    task automatic t_latency();
        run("R2 latency", 16'h3E00, 3'd0, 1'b0, 3'd0, 1'b0, 16'h4000);
        @(negedge clk);
        chk("R2 valid drops", {31'h0, out_valid}, 32'd0);
        chk("R2 result held", {16'h0, res_o}, 32'h4000);
    endtask

    task automatic t_near_even();
        run("R3 2.5", 16'h4100, 3'd0, 1'b0, 3'd0, 1'b0, 16'h4000);
        run("R3 1.5", 16'h3E00, 3'd0, 1'b0, 3'd0, 1'b0, 16'h4000);
        run("R3 3.5", 16'h4300, 3'd0, 1'b0, 3'd0, 1'b0, 16'h4400);
        run("R3 2.75", 16'h4180, 3'd0, 1'b0, 3'd0, 1'b0, 16'h4200);
        run("R3 reserved code", 16'h4100, 3'd6, 1'b0, 3'd0, 1'b0, 16'h4000);
    endtask

    task automatic t_directed();
        run("R4 down -1.5", 16'hBE00, 3'd1, 1'b0, 3'd0, 1'b0, 16'hC000);
        run("R4 down 1.5", 16'h3E00, 3'd1, 1'b0, 3'd0, 1'b0, 16'h3C00);
        run("R4 up 1.5", 16'h3E00, 3'd2, 1'b0, 3'd0, 1'b0, 16'h4000);
        run("R4 up -1.5", 16'hBE00, 3'd2, 1'b0, 3'd0, 1'b0, 16'hBC00);
    endtask

    task automatic t_zero_away();
        run("R5 zero -1.5", 16'hBE00, 3'd3, 1'b0, 3'd0, 1'b0, 16'hBC00);
        run("R5 zero 2.75", 16'h4180, 3'd3, 1'b0, 3'd0, 1'b0, 16'h4000);
        run("R5 away 2.5", 16'h4100, 3'd4, 1'b0, 3'd0, 1'b0, 16'h4200);
        run("R5 away -2.5", 16'hC100, 3'd4, 1'b0, 3'd0, 1'b0, 16'hC200);
    endtask

    task automatic t_dynamic();
        run("R6 dyn down", 16'h3E00, 3'd2, 1'b1, 3'd1, 1'b0, 16'h3C00);
        run("R6 dyn up", 16'h3E00, 3'd1, 1'b1, 3'd2, 1'b0, 16'h4000);
        run("R6 forced", 16'h3E00, 3'd1, 1'b0, 3'd2, 1'b0, 16'h3C00);
    endtask

    task automatic t_tiny();
        run("R7 0.5 even", 16'h3800, 3'd0, 1'b0, 3'd0, 1'b0, 16'h0000);
        run("R7 0.5 away", 16'h3800, 3'd4, 1'b0, 3'd0, 1'b0, 16'h3C00);
        run("R7 -0.25 even", 16'hB400, 3'd0, 1'b0, 3'd0, 1'b0, 16'h8000);
        run("R7 -0.25 down", 16'hB400, 3'd1, 1'b0, 3'd0, 1'b0, 16'hBC00);
        run("R7 0.25 up", 16'h3400, 3'd2, 1'b0, 3'd0, 1'b0, 16'h3C00);
        run("R7 0.75 even", 16'h3A00, 3'd0, 1'b0, 3'd0, 1'b0, 16'h3C00);
        run("R7 subnormal up", 16'h0001, 3'd2, 1'b0, 3'd0, 1'b0, 16'h3C00);
        run("R7 -subnormal zero", 16'h8001, 3'd3, 1'b0, 3'd0, 1'b0, 16'h8000);
        chk("R10 non-exact kept inexact clear", {30'h0, flags_o}, 32'd0);
    endtask

    task automatic t_pass();
        do_reset();
        run("R8 1024", 16'h6400, 3'd2, 1'b0, 3'd0, 1'b1, 16'h6400);
        run("R8 1025", 16'h6401, 3'd0, 1'b0, 3'd0, 1'b1, 16'h6401);
        run("R8 +inf", 16'h7C00, 3'd1, 1'b0, 3'd0, 1'b1, 16'h7C00);
        run("R8 -inf", 16'hFC00, 3'd2, 1'b0, 3'd0, 1'b1, 16'hFC00);
        run("R8 +0", 16'h0000, 3'd2, 1'b0, 3'd0, 1'b1, 16'h0000);
        run("R8 -0", 16'h8000, 3'd1, 1'b0, 3'd0, 1'b1, 16'h8000);
        chk("R8 no flags", {30'h0, flags_o}, 32'd0);
    endtask

    task automatic t_exact();
        do_reset();
        run("R9 exact 2.0", 16'h4000, 3'd0, 1'b0, 3'd0, 1'b1, 16'h4000);
        chk("R9 integral no inexact", {30'h0, flags_o}, 32'd0);
        run("R9 exact 1.5", 16'h3E00, 3'd3, 1'b0, 3'd0, 1'b1, 16'h3C00);
        chk("R9 inexact set", {30'h0, flags_o}, 32'd1);
        run("R10 non-exact after", 16'h3E00, 3'd3, 1'b0, 3'd0, 1'b0, 16'h3C00);
        chk("R10 inexact stays", {30'h0, flags_o}, 32'd1);
    endtask

    task automatic t_nan();
        do_reset();
        run("R11 qnan", 16'h7E45, 3'd0, 1'b0, 3'd0, 1'b1, 16'h7E45);
        chk("R11 qnan no flags", {30'h0, flags_o}, 32'd0);
        run("R11 snan", 16'h7D23, 3'd0, 1'b0, 3'd0, 1'b0, 16'h7F23);
        chk("R11 snan invalid", {30'h0, flags_o}, 32'd2);
        run("R12 exact 2.0", 16'h4000, 3'd0, 1'b0, 3'd0, 1'b1, 16'h4000);
        chk("R12 invalid sticky", {30'h0, flags_o}, 32'd2);
        run("R12 exact 1.5", 16'h3E00, 3'd0, 1'b0, 3'd0, 1'b1, 16'h4000);
        chk("R12 both set", {30'h0, flags_o}, 32'd3);
        run("R12 plain op", 16'h0000, 3'd0, 1'b0, 3'd0, 1'b0, 16'h0000);
        chk("R12 both kept", {30'h0, flags_o}, 32'd3);
    endtask

    initial begin
        t_reset();
        t_latency();
        t_near_even();
        t_directed();
        t_zero_away();
        t_dynamic();
        t_tiny();
        t_pass();
        t_exact();
        t_nan();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule